// File: doc/BRIEF.md
# Ring Oscillator Frequency Monitor

This block measures the speed of on-chip free-running oscillators to track process and voltage. Software picks one oscillator source and programs a measurement window as a number of reference clock cycles. It then enables the block and raises start. The reference domain opens a gate for exactly that many cycles. An edge counter, clocked by the selected oscillator, counts rising edges while the gate is open. When the gate has closed and the count has settled, the count is copied into the result register and the done flag rises.

The register interface is a single-cycle write port with a combinational read port. Offsets: control 0x0, window 0x4, status 0x8, result 0xC. Control writes are masked. The upper half-word of the write data enables the lower half-word bit by bit, so software can change start, enable or the source select without a read-modify-write. With a 24 MHz reference, a window of T microseconds is programmed as T*24.

Top module: `ring_freq_mon`

## Requirements
- R1: After reset, reads of control, window, status and result all return 0.
- R2: A write to control (0x0) updates lower bit n only when write bit 16+n is 1. Other bits keep their value. The control layout is: bit 0 start, bit 1 enable, bits [4:2] source select.
- R3: The window register (0x4) is written in full and reads back the stored count of reference cycles.
- R4: A rising edge of start while enable is 1 begins a measurement and clears done and result. A rising edge of start while enable is 0 has no effect: done and result keep their values.
- R5: Status bit 0 (0x8) rises after the window elapses, once the gate has closed in the oscillator domain. The result register (0xC) then holds the number of rising edges of the selected source seen during the window, within a few edges of synchronizer slack.
- R6: The source select is latched when the measurement starts. A change to the select field during a running measurement does not affect its count.
- R7: A source select at or above the number of implemented sources sets done one cycle after the start edge, with a result of 0.
- R8: A window value of 0 sets done one cycle after the start edge, with a result of 0.
- R9: Clearing start or enable during a measurement aborts it without setting done. A later measurement works normally.
- R10: The edge counter saturates at all ones and does not wrap.
- R11: While done stays set, the result register does not change until the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | NUM_SRC | Oscillator sources to be measured |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |

## Verification
The hardest state to reach from the ports is an abort that lands while the gate is open and its synchronized copy is still travelling between the domains. The stimulus starts a long window and drops start about twenty cycles in. It then waits for the drain to finish, confirms that done is still clear, and runs a fresh measurement to show that no stale gate or count leaked into it. Saturation is reached with the fastest source and a long window against a narrowed counter. Select latching is tested by rewriting the select field, through the mask, while the gate is open.

// File: rtl/rfm_pkg.sv
`timescale 1ns/1ps
package rfm_pkg;
  localparam int SEL_W  = 3;
  localparam int CTRL_W = SEL_W + 2;
  localparam int MASK_LSB = 16;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_WIN  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_RES  = 4'hC;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             start;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} meas_st_e;
endpackage

// File: rtl/rfm_regs.sv
`timescale 1ns/1ps
module rfm_regs
  import rfm_pkg::*;
#(
  parameter int WIN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output ctrl_t            ctrl_o,
  output logic [WIN_W-1:0] win_o
);
  logic              wr_ctrl, wr_win;
  logic [CTRL_W-1:0] wmask;

  assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_win  = wr_en_i && (addr_i == OFS_WIN);
  assign wmask   = wdata_i[MASK_LSB +: CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      win_o  <= '0;
    end else begin
      if (wr_ctrl) ctrl_o <= ctrl_t'((ctrl_o & ~wmask) | (wdata_i[CTRL_W-1:0] & wmask));
      if (wr_win)  win_o  <= wdata_i[WIN_W-1:0];
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[MASK_LSB]) |=> (ctrl_o.start == $past(ctrl_o.start))); // R2
  AST_WIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_win |=> (win_o == $past(wdata_i[WIN_W-1:0]))); // R3
endmodule

// File: rtl/rfm_window.sv
`timescale 1ns/1ps
module rfm_window
  import rfm_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int WIN_W   = 32,
  parameter int CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             echo_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             gate_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [SEL_W:0] NSRC = (SEL_W+1)'(NUM_SRC);

  meas_st_e         st_q;
  logic [WIN_W-1:0] rem_q;
  logic [1:0]       echo_q;
  logic             start_d, abort_q;
  logic             arm, keep, src_ok;

  assign arm    = ctrl_i.start && !start_d && ctrl_i.en;
  assign keep   = ctrl_i.start && ctrl_i.en;
  assign src_ok = {1'b0, ctrl_i.sel} < NSRC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rem_q    <= '0;
      echo_q   <= '0;
      start_d  <= 1'b0;
      abort_q  <= 1'b0;
      gate_o   <= 1'b0;
      sel_o    <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      start_d <= ctrl_i.start;
      echo_q  <= {echo_q[0], echo_i};
      unique case (st_q)
        ST_IDLE: if (arm) begin
          done_o   <= 1'b0;
          result_o <= '0;
          sel_o    <= ctrl_i.sel;
          if (win_i == '0 || !src_ok) begin
            done_o <= 1'b1;
          end else begin
            rem_q  <= win_i;
            gate_o <= 1'b1;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!keep) begin
            gate_o  <= 1'b0;
            abort_q <= 1'b1;
            st_q    <= ST_DRAIN;
          end else if (rem_q != WIN_W'(1)) begin
            rem_q <= rem_q - WIN_W'(1);
          end else if (echo_q[1]) begin
            // window done and the far side has seen the gate open
            gate_o  <= 1'b0;
            abort_q <= 1'b0;
            st_q    <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (!echo_q[1]) begin
          st_q <= ST_IDLE;
          if (!abort_q) begin
            done_o   <= 1'b1;
            result_o <= cnt_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !ctrl_i.en) |=> (st_q == ST_IDLE && $stable(done_o))); // R4
  AST_DONE_GATE_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !gate_o); // R5
  AST_BAD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && arm && !src_ok) |=> (done_o && result_o == '0)); // R7
  AST_ZERO_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && arm && win_i == '0) |=> (done_o && result_o == '0)); // R8
  AST_ABORT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !keep) |=> !done_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm) |=> $stable(result_o)); // R11
endmodule

// File: rtl/rfm_osc_cnt.sv
`timescale 1ns/1ps
module rfm_osc_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             gate_s_o
);
  logic [1:0] gs_q;
  logic       gd_q, open_edge;

  assign open_edge = gs_q[1] && !gd_q;
  assign gate_s_o  = gs_q[1];

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gs_q  <= '0;
      gd_q  <= 1'b0;
      cnt_o <= '0;
    end else begin
      gs_q <= {gs_q[0], gate_i};
      gd_q <= gs_q[1];
      if (open_edge)                         cnt_o <= '0;
      else if (gs_q[1] && cnt_o != '1)       cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  AST_SAT_HOLD: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (cnt_o == '1 && !open_edge) |=> (cnt_o == '1)); // R10
  AST_CLOSED_STABLE: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !gs_q[1] |=> $stable(cnt_o)); // R5
endmodule

// File: rtl/ring_freq_mon.sv
`timescale 1ns/1ps
module ring_freq_mon
  import rfm_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int WIN_W   = 32,
  parameter int CNT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] osc_clk_i,
  input  logic               wr_en_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o
);
  ctrl_t            ctrl;
  logic [WIN_W-1:0] win;
  logic [SEL_W-1:0] sel;
  logic             gate, echo, done, osc_clk;
  logic [CNT_W-1:0] cnt, result;

  rfm_regs #(.WIN_W(WIN_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .win_o(win)
  );

  rfm_window #(.NUM_SRC(NUM_SRC), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_window (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .win_i(win), .echo_i(echo), .cnt_i(cnt),
    .gate_o(gate), .sel_o(sel), .done_o(done), .result_o(result)
  );

  // select is only changed while the gate and its echo are low
  always_comb begin
    osc_clk = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel == SEL_W'(i)) osc_clk = osc_clk_i[i];
  end

  rfm_osc_cnt #(.CNT_W(CNT_W)) u_osc_cnt (
    .osc_clk_i(osc_clk), .rst_ni, .gate_i(gate), .cnt_o(cnt), .gate_s_o(echo)
  );

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rdata_o = 32'(ctrl);
      OFS_WIN:  rdata_o = 32'(win);
      OFS_STAT: rdata_o = {31'b0, done};
      OFS_RES:  rdata_o = 32'(result);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: tb/ring_freq_mon_tb.sv
`timescale 1ns/1ps
module ring_freq_mon_tb;
  localparam int NSRC = 3;
  localparam int CW   = 8;
  localparam int TREF = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] osc = '0;
  logic            wr_en = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  int total = 0, bad = 0;
  bit finished = 0;

  ring_freq_mon #(.NUM_SRC(NSRC), .WIN_W(32), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #10 clk = ~clk;
  always #5  osc[0] = ~osc[0];
  always #7  osc[1] = ~osc[1];
  always #3  osc[2] = ~osc[2];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, logic [31:0] act, int lo, int hi);
    total++;
    if (int'(act) < lo || int'(act) > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic arm(int sel, int w);
    wr(4'h0, 32'h0001_0000);
    wr(4'h0, 32'h0002_0002);
    wr(4'h0, {16'h001C, 11'b0, 3'(sel), 2'b00});
    wr(4'h4, 32'(w));
    wr(4'h0, 32'h0001_0001);
  endtask

  task automatic wait_done(output logic ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      rd(4'h8, v);
      ok = v[0];
    end
  endtask

  task automatic measure(string tag, int sel, int w, int tosc);
    logic ok; logic [31:0] v; int e;
    arm(sel, w);
    wait_done(ok);
    chk({tag, " done"}, 32'(ok), 1);
    rd(4'hC, v);
    e = (w * TREF) / tosc;
    if (e > 255) chk({tag, " saturated"}, v, 255);
    else chk_rng({tag, " count"}, v, e - 3, e + 3);
    wr(4'h0, 32'h0001_0000);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      chk("R1 reset value", v, 0);
    end
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(4'h0, 32'h001E_0016);         // en=1 sel=5, start untouched
    rd(4'h0, v); chk("R2 masked write", v, 32'h16);
    wr(4'h0, 32'h0002_0000);         // clear en only
    rd(4'h0, v); chk("R2 per-bit mask", v, 32'h14);
    wr(4'h0, 32'h0000_001F);         // no mask bits: no change
    rd(4'h0, v); chk("R2 zero mask", v, 32'h14);
    wr(4'h0, 32'h001F_0000);
  endtask

  task automatic t_window_reg;
    logic [31:0] v;
    wr(4'h4, 32'hA5C3_0F18);
    rd(4'h4, v); chk("R3 window readback", v, 32'hA5C3_0F18);
  endtask

  task automatic t_sources;
    measure("R5 src0", 0, 25, 10);
    measure("R6 src1", 1, 25, 14);
    measure("R6 src2", 2, 25, 6);
    measure("R5 long window", 0, 50, 10);
  endtask

  task automatic t_latch_sel;
    logic ok; logic [31:0] v;
    arm(0, 25);
    wr(4'h0, 32'h001C_0008);         // sel -> 2 mid-run
    rd(4'h0, v); chk("R6 select field rewritten", v[4:2], 2);
    wait_done(ok);
    chk("R6 done", 32'(ok), 1);
    rd(4'hC, v); chk_rng("R6 latched select", v, 47, 53);
    wr(4'h0, 32'h0001_0000);
  endtask

  task automatic t_stable;
    logic [31:0] a, b;
    measure("R11 setup", 1, 25, 14);
    rd(4'hC, a);
    repeat (50) @(negedge clk);
    rd(4'hC, b);
    chk("R11 result stable", b, a);
  endtask

  task automatic t_enable_gate;
    logic [31:0] a, v;
    rd(4'hC, a);
    wr(4'h0, 32'h0003_0000);
    wr(4'h0, 32'h0001_0001);         // start rise with en=0
    repeat (60) @(negedge clk);
    rd(4'h8, v); chk("R4 done kept when disabled", v, 1);
    rd(4'hC, v); chk("R4 result kept when disabled", v, a);
    wr(4'h0, 32'h0001_0000);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    arm(0, 200);
    repeat (20) @(negedge clk);
    wr(4'h0, 32'h0001_0000);
    repeat (100) @(negedge clk);
    rd(4'h8, v); chk("R9 no done after abort", v, 0);
    rd(4'hC, v); chk("R9 result cleared by start", v, 0);
    measure("R9 after abort", 0, 25, 10);
    arm(1, 200);
    repeat (20) @(negedge clk);
    wr(4'h0, 32'h0002_0000);         // drop enable
    repeat (100) @(negedge clk);
    rd(4'h8, v); chk("R9 no done after enable drop", v, 0);
    wr(4'h0, 32'h0001_0000);
  endtask

  task automatic t_zero_win;
    logic [31:0] v;
    wr(4'h0, 32'h0002_0002);
    wr(4'h0, 32'h001C_0000);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0001_0001);
    rd(4'h8, v); chk("R8 done not yet", v, 0);
    @(negedge clk);
    rd(4'h8, v); chk("R8 done after one cycle", v, 1);
    rd(4'hC, v); chk("R8 zero count", v, 0);
    wr(4'h0, 32'h0001_0000);
  endtask

  task automatic t_bad_src;
    logic [31:0] v;
    arm(1, 200);
    repeat (20) @(negedge clk);
    wr(4'h0, 32'h0001_0000);
    repeat (100) @(negedge clk);
    wr(4'h0, 32'h001C_0014);         // sel=5, invalid
    wr(4'h4, 32'd25);
    wr(4'h0, 32'h0001_0001);
    rd(4'h8, v); chk("R7 done not yet", v, 0);
    @(negedge clk);
    rd(4'h8, v); chk("R7 done after one cycle", v, 1);
    rd(4'hC, v); chk("R7 zero count", v, 0);
    wr(4'h0, 32'h0001_0000);
  endtask

  task automatic t_saturate;
    measure("R10 saturation", 2, 200, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_window_reg();
    t_sources();
    t_latch_sel();
    t_stable();
    t_enable_gate();
    t_abort();
    t_zero_win();
    t_bad_src();
    t_saturate();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TREF * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule